// File: doc/BRIEF.md
# Flagged 32-bit Multi-Operation ALU

This block is a purely combinational arithmetic logic unit. It takes two operands and a 4-bit operation code. It returns a data result together with five status flags: carry, overflow, less-than, equal-to and zero. The operations are add, unsigned multiply keeping the low half of the product, subtract, three shifts, bitwise AND, OR, XOR and NOT, and an unsigned compare. Shifts and NOT use only operand `a`, and the shift distance comes from the low five bits of `b`.

Each flag has a meaning for one operation, or a small set of them, and is held low for every other code. Carry applies to add and subtract. Overflow applies to multiply. Less-than and equal-to apply to compare. The zero flag follows the result for every defined code except compare, where it is held low. Codes 11 to 15 are undefined: they drive a zero result and leave every flag low.

Top module: `flag_alu`

## Requirements
- R1: Code 0 (add) gives `res = a + b` modulo 2^32, and `carry_o` is the carry out of bit 31.
- R2: Code 2 (subtract) gives `res = a - b` modulo 2^32, and `carry_o` is 1 exactly when `a >= b` taken as unsigned values.
- R3: Code 1 (multiply) gives the low 32 bits of the unsigned 64-bit product `a*b`. `ovf_o` is 1 exactly when any of product bits 63..32 is set, which includes bit 32.
- R4: Code 3 shifts `a` left, code 4 shifts `a` right logically, and code 5 shifts `a` right while copying `a[31]` into the vacated bits. The distance is `b[4:0]`, and `b[31:5]` has no effect.
- R5: Code 6 gives `a & b`, code 7 gives `a | b`, code 9 gives `a ^ b`, and code 8 gives `~a` whatever the value of `b`.
- R6: Code 10 (compare) sets `lt_o` when `a < b` unsigned and `eq_o` when `a == b`. It drives `res` to 0 and holds `zero_o` at 0.
- R7: For codes 0 to 9, `zero_o` is 1 exactly when `res` is all zeros.
- R8: Codes 11 to 15 drive `res` to 0 and hold all five flags at 0.
- R9: `carry_o` is 0 for every code other than 0 and 2. `ovf_o` is 0 for every code other than 1. `lt_o` and `eq_o` are 0 for every code other than 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| a | input | 32 | First operand; the only data operand for shifts and NOT |
| b | input | 32 | Second operand; bits 4..0 give the shift distance |
| res | output | 32 | Data result |
| carry_o | output | 1 | Carry for add, no-borrow for subtract |
| ovf_o | output | 1 | Multiply product exceeds 32 bits |
| lt_o | output | 1 | Compare: a below b (unsigned) |
| eq_o | output | 1 | Compare: a equal to b |
| zero_o | output | 1 | Result is all zeros (not during compare) |

## Verification
Each time the inputs change, the assertions check the rules that scope the flags. Carry, overflow, less-than and equal-to must stay low outside their codes. The compare code must suppress the zero flag and the result, and less-than must never coincide with equal-to. For codes 0 to 9, the zero flag must agree with the result, and the undefined codes must drive a quiet output. The bench scenarios are needed for the arithmetic values themselves: sums and their carries, low products and overflow at the 2^32 boundary, shift distances up to 31 with sign fill, and the insensitivity to `b[31:5]` and to `b` under NOT. They use operands at the extremes and random operands.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_MUL = 4'd1,
        OP_SUB = 4'd2,
        OP_SLL = 4'd3,
        OP_SRL = 4'd4,
        OP_SRA = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_NOT = 4'd8,
        OP_XOR = 4'd9,
        OP_CMP = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic lt;
        logic eq;
        logic zero;
    } alu_flags_t;

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0]   total;
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = total[W-1:0];
        cout  = total[W];
    end
endmodule

// File: rtl/flag_alu_mul.sv
module flag_alu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic         hi_nz
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;

    always_comb begin
        prod  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        lo    = prod[W-1:0];
        hi_nz = |prod[PW-1:W];
    end
endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   y
);
    logic [W-1:0] a_rev;
    logic [W-1:0] src;
    logic [W-1:0] out_rev;
    logic [W-1:0] stage [SHW+1];
    logic         fill;

    // bit reversal lets one right-shifting network also shift left
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign a_rev[i]   = a[W-1-i];
        assign out_rev[i] = stage[SHW][W-1-i];
    end

    assign fill     = arith & ~left & a[W-1];
    assign src      = left ? a_rev : a;
    assign stage[0] = src;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
    end

    assign y = left ? out_rev : stage[SHW];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             lt_o,
    output logic             eq_o,
    output logic             zero_o
);
    localparam int SHW = $clog2(WIDTH);

    alu_op_e          op_e;
    logic             sub_sel;
    logic [WIDTH-1:0] as_sum;
    logic             as_cout;
    logic [WIDTH-1:0] mul_lo;
    logic             mul_hi;
    logic [WIDTH-1:0] sh_y;
    logic             sh_left;
    logic             sh_arith;
    logic [WIDTH-1:0] res_d;
    alu_flags_t       flags_d;

    assign op_e     = alu_op_e'(op);
    assign sub_sel  = (op_e == OP_SUB) || (op_e == OP_CMP);
    assign sh_left  = (op_e == OP_SLL);
    assign sh_arith = (op_e == OP_SRA);

    flag_alu_addsub #(.W(WIDTH)) u_addsub (
        .a    (a),
        .b    (b),
        .sub  (sub_sel),
        .sum  (as_sum),
        .cout (as_cout)
    );

    flag_alu_mul #(.W(WIDTH)) u_mul (
        .a     (a),
        .b     (b),
        .lo    (mul_lo),
        .hi_nz (mul_hi)
    );

    flag_alu_shift #(.W(WIDTH), .SHW(SHW)) u_shift (
        .a     (a),
        .amt   (b[SHW-1:0]),
        .left  (sh_left),
        .arith (sh_arith),
        .y     (sh_y)
    );

    always_comb begin
        res_d   = '0;
        flags_d = '0;
        unique case (op_e)
            OP_ADD: begin
                res_d         = as_sum;
                flags_d.carry = as_cout;
            end
            OP_SUB: begin
                res_d         = as_sum;
                flags_d.carry = as_cout;
            end
            OP_MUL: begin
                res_d       = mul_lo;
                flags_d.ovf = mul_hi;
            end
            OP_SLL, OP_SRL, OP_SRA: res_d = sh_y;
            OP_AND: res_d = a & b;
            OP_OR:  res_d = a | b;
            OP_NOT: res_d = ~a;
            OP_XOR: res_d = a ^ b;
            OP_CMP: begin
                // subtract path: no borrow means a >= b
                flags_d.lt = ~as_cout;
                flags_d.eq = (as_sum == '0);
            end
            default: res_d = '0;
        endcase
        if (op_e != OP_CMP && op <= 4'd9) begin
            flags_d.zero = (res_d == '0);
        end
    end

    assign res     = res_d;
    assign carry_o = flags_d.carry;
    assign ovf_o   = flags_d.ovf;
    assign lt_o    = flags_d.lt;
    assign eq_o    = flags_d.eq;
    assign zero_o  = flags_d.zero;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [3:0]       op,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] res,
    input logic             carry_o,
    input logic             ovf_o,
    input logic             lt_o,
    input logic             eq_o,
    input logic             zero_o
);
    always_comb begin
        if (op != 4'd0 && op != 4'd2)
            p_carry_scope_r9: assert (!carry_o) else $error("carry outside add/sub");
    end

    always_comb begin
        if (op != 4'd1)
            p_no_overflow_r9: assert (!ovf_o) else $error("overflow outside multiply");
    end

    always_comb begin
        if (op != 4'd10)
            p_cmp_scope_r9: assert (!lt_o && !eq_o) else $error("compare flag outside compare");
    end

    always_comb begin
        if (op == 4'd10)
            p_cmp_quiet_r6: assert (!zero_o && res == '0) else $error("compare not quiet");
    end

    always_comb begin
        p_lt_eq_excl_r6: assert (!(lt_o && eq_o)) else $error("lt and eq both set");
    end

    always_comb begin
        if (op == 4'd10)
            p_eq_match_r6: assert (eq_o == (a == b)) else $error("eq mismatch");
    end

    always_comb begin
        if (op <= 4'd9)
            p_zero_track_r7: assert (zero_o == (res == '0)) else $error("zero flag mismatch");
    end

    always_comb begin
        if (op >= 4'd11)
            p_unused_quiet_r8: assert (res == '0 && !carry_o && !ovf_o && !lt_o && !eq_o && !zero_o)
                else $error("unused code not quiet");
    end
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .op      (op),
    .a       (a),
    .b       (b),
    .res     (res),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .lt_o    (lt_o),
    .eq_o    (eq_o),
    .zero_o  (zero_o)
);

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;
    logic        clk = 1'b0;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic [31:0] res;
    logic        carry_o, ovf_o, lt_o, eq_o, zero_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flag_alu dut (
        .op(op), .a(a), .b(b), .res(res),
        .carry_o(carry_o), .ovf_o(ovf_o), .lt_o(lt_o), .eq_o(eq_o), .zero_o(zero_o)
    );

    // expected values
    logic [31:0] e_res;
    logic e_c, e_v, e_lt, e_eq, e_z;

    task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [63:0] p;
        logic [32:0] s;
        int sh;
        sh = int'(y[4:0]);
        e_res = 0; e_c = 0; e_v = 0; e_lt = 0; e_eq = 0;
        case (o)
            4'd0: begin s = {1'b0, x} + {1'b0, y}; e_res = s[31:0]; e_c = s[32]; end
            4'd1: begin p = {32'd0, x} * {32'd0, y}; e_res = p[31:0]; e_v = (p[63:32] != 0); end
            4'd2: begin e_res = x - y; e_c = (x >= y); end
            4'd3: e_res = x << sh;
            4'd4: e_res = x >> sh;
            4'd5: e_res = 32'($signed(x) >>> sh);
            4'd6: e_res = x & y;
            4'd7: e_res = x | y;
            4'd8: e_res = ~x;
            4'd9: e_res = x ^ y;
            4'd10: begin e_lt = (x < y); e_eq = (x == y); end
            default: e_res = 0;
        endcase
        e_z = (o <= 4'd9) && (e_res == 0);
    endtask

    function automatic string res_tag(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R3";
            4'd2: return "R2";
            4'd3, 4'd4, 4'd5: return "R4";
            4'd6, 4'd7, 4'd8, 4'd9: return "R5";
            4'd10: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h", tag, what, op, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        string ft;
        @(posedge clk);
        op = o; a = x; b = y;
        model(o, x, y);
        @(negedge clk);
        chk(res_tag(o), "res", res, e_res);
        ft = (o == 4'd0) ? "R1" : (o == 4'd2) ? "R2" : (o > 4'd10) ? "R8" : "R9";
        chk(ft, "carry", {31'd0, carry_o}, {31'd0, e_c});
        ft = (o == 4'd1) ? "R3" : (o > 4'd10) ? "R8" : "R9";
        chk(ft, "ovf", {31'd0, ovf_o}, {31'd0, e_v});
        ft = (o == 4'd10) ? "R6" : (o > 4'd10) ? "R8" : "R9";
        chk(ft, "lt", {31'd0, lt_o}, {31'd0, e_lt});
        chk(ft, "eq", {31'd0, eq_o}, {31'd0, e_eq});
        ft = (o == 4'd10) ? "R6" : (o > 4'd10) ? "R8" : "R7";
        chk(ft, "zero", {31'd0, zero_o}, {31'd0, e_z});
    endtask

    logic [31:0] corner [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0001_0000};

    initial begin
        op = 0; a = 0; b = 0;
        // reset-like idle state: add of zeros gives zero flag only (R7)
        @(negedge clk);
        chk("R7", "idle zero", {31'd0, zero_o}, 32'd1);
        chk("R1", "idle res", res, 32'd0);
        // boundary cases
        apply(4'd0, 32'hFFFF_FFFF, 32'h1);          // R1 carry out, zero result
        apply(4'd1, 32'h0001_0000, 32'h0001_0000);  // R3 product exactly 2^32
        apply(4'd1, 32'h0000_FFFF, 32'h0001_0001);  // R3 fits
        apply(4'd2, 32'h5, 32'h5);                  // R2 equal gives carry 1
        apply(4'd2, 32'h4, 32'h5);                  // R2 negative gives carry 0
        apply(4'd5, 32'h8000_0000, 32'hFFFF_FFFF);  // R4 distance 31 with upper b set
        apply(4'd3, 32'h1, 32'hFFFF_FFE0);          // R4 distance 0, b[31:5] ignored
        apply(4'd8, 32'h1234_5678, 32'hDEAD_BEEF);  // R5 NOT ignores b
        apply(4'd10, 32'h0, 32'h0);                 // R6 equal, zero suppressed
        apply(4'd10, 32'h7FFF_FFFF, 32'h8000_0000); // R6 unsigned less-than
        apply(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R8 quiet
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    apply(4'(o), corner[i], corner[j]);
        for (int n = 0; n < 4000; n++)
            apply(4'($urandom_range(0, 15)), $urandom, $urandom);
        for (int n = 0; n < 500; n++)
            apply(4'($urandom_range(3, 5)), $urandom, $urandom);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule